// File: doc/BRIEF.md
# Tag-Tracking Operand Wait Array

This block is a small pool of waiting slots for arithmetic operations in an out-of-order core. Each slot holds an operation code and two source operands. The issue logic presents each source either as a ready value or as the tag of the slot that will produce it. Slot tags run from 1 to N, and tag 0 means "no producer; the value is present".

While an operand is missing, the slot watches the single result bus. When the bus carries the awaited tag, the slot takes the value from the bus. A slot whose two operands are both present becomes eligible. A selector sends the lowest-numbered eligible slot, one per cycle, to a stand-in execution pipe with a fixed latency. The pipe puts the result on the result bus together with the producing slot's tag. In that same cycle every waiting slot snoops the bus, and the producing slot releases itself.

The upstream rename logic uses `iss_tag` to record which slot now owns a destination register. It then passes that tag to later consumers in place of a value.

Top module: `rs_array`

## Requirements
- R1: After reset no slot is occupied. `iss_ready` is 1, `iss_tag` is 1 and `cdb_valid` is 0.
- R2: An issue is accepted when `iss_valid` and `iss_ready` are both high. It goes into the free slot with the lowest number, and that slot's number (1..N) is shown on `iss_tag` during the issue cycle.
- R3: At issue, a source with tag 0 takes the supplied value. A source with a nonzero tag waits for that producer instead of using the supplied value.
- R4: Every occupied slot that waits on tag t takes `cdb_value` and stops waiting when the bus carries a valid result with tag t. Each of the two sources is handled on its own.
- R5: If the awaited tag is on the result bus in the same cycle as the issue, the issuing slot takes the bus value at once.
- R6: A slot is dispatched only when neither source is waiting. Each issued operation is dispatched exactly once.
- R7: When several slots are eligible in the same cycle, the one with the lowest number is dispatched first.
- R8: A dispatched operation appears on the bus, LAT cycles after dispatch, with its own slot tag. The value depends on the 2-bit op: 0 gives a+b, 1 gives a-b, 2 gives a xor b, 3 gives a and b, all modulo 2^DW. At most one result is broadcast per cycle, and the producing slot becomes free on the following edge.
- R9: When every slot is occupied, `iss_ready` is 0 and an asserted `iss_valid` is ignored. No slot contents change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 2 | Operation code |
| iss_a_tag | input | TW | Producer tag of source a, 0 = value present |
| iss_a_val | input | DW | Value of source a |
| iss_b_tag | input | TW | Producer tag of source b, 0 = value present |
| iss_b_val | input | DW | Value of source b |
| iss_ready | output | 1 | At least one slot is free |
| iss_tag | output | TW | Tag given to an issue in this cycle |
| cdb_valid | output | 1 | Result bus carries a result |
| cdb_tag | output | TW | Tag of the producing slot |
| cdb_value | output | DW | Result value |

## Verification
The assertions assume that a nonzero source tag at issue always names a slot that is currently occupied and that has not yet been freed, or that is being broadcast in the issue cycle. Tags above N never appear. The stimulus keeps to this through a bench-side rename table. Each register either holds a value or names the slot that owns it, and a register's tag is cleared on the same cycle that its result is broadcast. Consumers therefore only ever see live tags. A tag that is being broadcast is handed out deliberately, and this exercises the same-cycle capture.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    FU_ADD = 2'd0,
    FU_SUB = 2'd1,
    FU_XOR = 2'd2,
    FU_AND = 2'd3
  } fu_op_e;
endpackage

// File: rtl/rs_pick_low.sv
module rs_pick_low #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
      end
    end
    any = |req;
  end
endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int          DW     = 32,
  parameter int          TW     = 3,
  parameter logic [TW-1:0] MY_TAG = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_we,
  input  fu_op_e        iss_op,
  input  logic [TW-1:0] iss_qa,
  input  logic [DW-1:0] iss_va,
  input  logic [TW-1:0] iss_qb,
  input  logic [DW-1:0] iss_vb,
  input  logic          bc_valid,
  input  logic [TW-1:0] bc_tag,
  input  logic [DW-1:0] bc_val,
  input  logic          grant,
  output logic          busy,
  output logic          ready,
  output fu_op_e        op,
  output logic [DW-1:0] va,
  output logic [DW-1:0] vb
);
  logic          busy_q, busy_d, sent_q, sent_d;
  logic [TW-1:0] qa_q, qa_d, qb_q, qb_d;
  fu_op_e        op_q, op_d;
  logic [DW-1:0] va_q, va_d, vb_q, vb_d;
  logic          hit_a, hit_b, byp_a, byp_b, done, dat_en;

  always_comb begin
    byp_a  = bc_valid && (iss_qa != '0) && (iss_qa == bc_tag);
    byp_b  = bc_valid && (iss_qb != '0) && (iss_qb == bc_tag);
    hit_a  = busy_q && bc_valid && (qa_q != '0) && (qa_q == bc_tag);
    hit_b  = busy_q && bc_valid && (qb_q != '0) && (qb_q == bc_tag);
    done   = busy_q && bc_valid && (bc_tag == MY_TAG);
    busy_d = busy_q;
    sent_d = sent_q;
    qa_d   = qa_q;
    qb_d   = qb_q;
    op_d   = op_q;
    va_d   = va_q;
    vb_d   = vb_q;
    if (iss_we) begin
      busy_d = 1'b1;
      sent_d = 1'b0;
      op_d   = iss_op;
      qa_d   = byp_a ? '0 : iss_qa;
      va_d   = byp_a ? bc_val : iss_va;
      qb_d   = byp_b ? '0 : iss_qb;
      vb_d   = byp_b ? bc_val : iss_vb;
    end else begin
      if (hit_a) begin
        qa_d = '0;
        va_d = bc_val;
      end
      if (hit_b) begin
        qb_d = '0;
        vb_d = bc_val;
      end
      if (grant) sent_d = 1'b1;
      if (done)  busy_d = 1'b0;
    end
    dat_en = iss_we | hit_a | hit_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sent_q <= 1'b0;
      qa_q   <= '0;
      qb_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sent_q <= sent_d;
      qa_q   <= qa_d;
      qb_q   <= qb_d;
    end
  end

  always_ff @(posedge clk) begin
    if (dat_en) begin
      op_q <= op_d;
      va_q <= va_d;
      vb_q <= vb_d;
    end
  end

  assign busy  = busy_q;
  assign ready = busy_q && !sent_q && (qa_q == '0) && (qb_q == '0);
  assign op    = op_q;
  assign va    = va_q;
  assign vb    = vb_q;
endmodule

// File: rtl/rs_fu_stub.sv
module rs_fu_stub
  import rs_pkg::*;
#(
  parameter int DW  = 32,
  parameter int TW  = 3,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [TW-1:0] in_tag,
  input  fu_op_e        in_op,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  output logic          out_valid,
  output logic [TW-1:0] out_tag,
  output logic [DW-1:0] out_val
);
  logic [LAT-1:0]          vld_q;
  logic [LAT-1:0][TW-1:0]  tag_q;
  logic [LAT-1:0][DW-1:0]  res_q;
  logic [DW-1:0]           res_d;

  always_comb begin
    unique case (in_op)
      FU_ADD:  res_d = in_a + in_b;
      FU_SUB:  res_d = in_a - in_b;
      FU_XOR:  res_d = in_a ^ in_b;
      default: res_d = in_a & in_b;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= {vld_q[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      tag_q[0] <= in_tag;
      res_q[0] <= res_d;
    end
    for (int s = 1; s < LAT; s++) begin
      if (vld_q[s-1]) begin
        tag_q[s] <= tag_q[s-1];
        res_q[s] <= res_q[s-1];
      end
    end
  end

  assign out_valid = vld_q[LAT-1];
  assign out_tag   = tag_q[LAT-1];
  assign out_val   = res_q[LAT-1];
endmodule

// File: rtl/rs_array.sv
module rs_array
  import rs_pkg::*;
#(
  parameter int N   = 4,
  parameter int DW  = 32,
  parameter int LAT = 3,
  localparam int TW = $clog2(N + 1),
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [1:0]    iss_op,
  input  logic [TW-1:0] iss_a_tag,
  input  logic [DW-1:0] iss_a_val,
  input  logic [TW-1:0] iss_b_tag,
  input  logic [DW-1:0] iss_b_val,
  output logic          iss_ready,
  output logic [TW-1:0] iss_tag,
  output logic          cdb_valid,
  output logic [TW-1:0] cdb_tag,
  output logic [DW-1:0] cdb_value
);
  logic [N-1:0]          busy, ready, grant, free_oh, iss_we;
  logic                  free_any, disp_any;
  logic [IW-1:0]         free_idx, disp_idx;
  fu_op_e                ent_op [N];
  logic [DW-1:0]         ent_va [N];
  logic [DW-1:0]         ent_vb [N];
  fu_op_e                disp_op;
  logic [DW-1:0]         disp_a, disp_b;

  rs_pick_low #(.N(N), .IW(IW)) u_alloc (
    .req(~busy), .gnt(free_oh), .any(free_any), .idx(free_idx)
  );

  rs_pick_low #(.N(N), .IW(IW)) u_sel (
    .req(ready), .gnt(grant), .any(disp_any), .idx(disp_idx)
  );

  assign iss_ready = free_any;
  assign iss_tag   = TW'(free_idx) + TW'(1);
  assign iss_we    = (iss_valid && free_any) ? free_oh : '0;

  for (genvar g = 0; g < N; g++) begin : g_ent
    rs_entry #(.DW(DW), .TW(TW), .MY_TAG(TW'(g + 1))) u_ent (
      .clk(clk), .rst_n(rst_n),
      .iss_we(iss_we[g]), .iss_op(fu_op_e'(iss_op)),
      .iss_qa(iss_a_tag), .iss_va(iss_a_val),
      .iss_qb(iss_b_tag), .iss_vb(iss_b_val),
      .bc_valid(cdb_valid), .bc_tag(cdb_tag), .bc_val(cdb_value),
      .grant(grant[g]),
      .busy(busy[g]), .ready(ready[g]),
      .op(ent_op[g]), .va(ent_va[g]), .vb(ent_vb[g])
    );
  end

  always_comb begin
    disp_op = FU_ADD;
    disp_a  = '0;
    disp_b  = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) begin
        disp_op = ent_op[i];
        disp_a  = ent_va[i];
        disp_b  = ent_vb[i];
      end
    end
  end

  rs_fu_stub #(.DW(DW), .TW(TW), .LAT(LAT)) u_fu (
    .clk(clk), .rst_n(rst_n),
    .in_valid(disp_any), .in_tag(TW'(disp_idx) + TW'(1)),
    .in_op(disp_op), .in_a(disp_a), .in_b(disp_b),
    .out_valid(cdb_valid), .out_tag(cdb_tag), .out_val(cdb_value)
  );
endmodule

// File: rtl/rs_array_chk.sv
module rs_array_chk #(
  parameter int N  = 4,
  parameter int TW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  busy,
  input logic [N-1:0]  ready,
  input logic [N-1:0]  grant,
  input logic [N-1:0]  iss_we,
  input logic          cdb_valid,
  input logic [TW-1:0] cdb_tag
);
  logic [N-1:0] bc_oh;
  always_comb begin
    bc_oh = '0;
    for (int i = 0; i < N; i++) bc_oh[i] = cdb_valid && (cdb_tag == TW'(i + 1));
  end

  a_r2_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(iss_we));
  a_r2_into_free: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_we & busy) == '0);
  a_r6_grant_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~ready) == '0));
  a_r7_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> (((grant - 1'b1) & ready) == '0));
  a_r8_tag_live: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |-> ((bc_oh & busy) != '0));
  a_r8_slot_freed: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_oh != '0) |=> ((busy & $past(bc_oh)) == '0));
  a_r9_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy == '1) |-> (iss_we == '0));
endmodule

bind rs_array rs_array_chk #(.N(N), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ready(ready), .grant(grant),
  .iss_we(iss_we), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag)
);

// File: tb/test_rs_array.sv
`timescale 1ns/1ps
module test_rs_array;
  localparam int N   = 4;
  localparam int DW  = 32;
  localparam int LAT = 3;
  localparam int TW  = $clog2(N + 1);
  localparam int NR  = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          iss_valid;
  logic [1:0]    iss_op;
  logic [TW-1:0] iss_a_tag, iss_b_tag;
  logic [DW-1:0] iss_a_val, iss_b_val;
  logic          iss_ready, cdb_valid;
  logic [TW-1:0] iss_tag, cdb_tag;
  logic [DW-1:0] cdb_value;

  always #2.5 clk = ~clk;

  rs_array #(.N(N), .DW(DW), .LAT(LAT)) i_rs_array (.*);

  int            n_chk = 0, n_fail = 0;
  bit            mbusy   [1:N];
  logic [DW-1:0] exp_res [1:N];
  int            rtag    [NR];
  logic [DW-1:0] rval    [NR];
  int            log_tag [256];
  int            n_log;

  function automatic logic [DW-1:0] fu_model(input logic [1:0] op, input logic [DW-1:0] a, b);
    case (op)
      2'd0:    return a + b;
      2'd1:    return a - b;
      2'd2:    return a ^ b;
      default: return a & b;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit model_empty();
    for (int t = 1; t <= N; t++) if (mbusy[t]) return 1'b0;
    return 1'b1;
  endfunction

  // One cycle of monitoring and driving; the caller is at a falling edge.
  task automatic step(input bit do_iss, input logic [1:0] op, input int ra, input int rb, input int rd);
    int            ftag, bt;
    logic [DW-1:0] a, b;
    ftag = 0;
    for (int t = N; t >= 1; t--) if (!mbusy[t]) ftag = t;
    chk(iss_ready == (ftag != 0), "R2/R9", "iss_ready", iss_ready, ftag != 0);
    if (ftag != 0) chk(iss_tag == TW'(ftag), "R2", "iss_tag lowest free", iss_tag, ftag);
    bt = cdb_valid ? int'(cdb_tag) : 0;
    if (cdb_valid) begin
      chk(bt >= 1 && bt <= N && mbusy[bt], "R8", "broadcast tag live", bt, 0);
      if (bt >= 1 && bt <= N) begin
        chk(cdb_value == exp_res[bt], "R3/R4/R8", "broadcast value", cdb_value, exp_res[bt]);
        if (n_log < 256) log_tag[n_log] = bt;
        n_log++;
      end
    end
    if (do_iss && ftag != 0) begin
      a = (rtag[ra] != 0) ? exp_res[rtag[ra]] : rval[ra];
      b = (rtag[rb] != 0) ? exp_res[rtag[rb]] : rval[rb];
      iss_valid = 1'b1;
      iss_op    = op;
      iss_a_tag = TW'(rtag[ra]);
      iss_b_tag = TW'(rtag[rb]);
      // R3: a waiting source carries a junk value that must not be used
      iss_a_val = (rtag[ra] != 0) ? $urandom() : rval[ra];
      iss_b_val = (rtag[rb] != 0) ? $urandom() : rval[rb];
      exp_res[ftag] = fu_model(op, a, b);
    end else if (do_iss) begin
      // R9: request while full, with arbitrary contents
      iss_valid = 1'b1;
      iss_op    = 2'($urandom());
      iss_a_tag = '0;
      iss_b_tag = '0;
      iss_a_val = $urandom();
      iss_b_val = $urandom();
    end else begin
      iss_valid = 1'b0;
    end
    if (bt >= 1 && bt <= N) begin
      for (int r = 0; r < NR; r++) if (rtag[r] == bt) begin rtag[r] = 0; rval[r] = exp_res[bt]; end
      mbusy[bt] = 1'b0;
    end
    if (do_iss && ftag != 0) begin
      rtag[rd]    = ftag;
      mbusy[ftag] = 1'b1;
    end
  endtask

  task automatic drain();
    int k;
    k = 0;
    while (!model_empty() && k < 300) begin
      @(negedge clk);
      step(1'b0, 2'd0, 0, 0, 0);
      k++;
    end
    chk(model_empty(), "R6/R8", "all issued operations broadcast", k, 0);
    @(negedge clk);
    step(1'b0, 2'd0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    iss_valid = 1'b0; iss_op = '0;
    iss_a_tag = '0; iss_b_tag = '0; iss_a_val = '0; iss_b_val = '0;
    for (int t = 1; t <= N; t++) begin mbusy[t] = 1'b0; exp_res[t] = '0; end
    for (int r = 0; r < NR; r++) begin rtag[r] = 0; rval[r] = $urandom(); end
    n_log = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(iss_ready == 1'b1, "R1", "iss_ready after reset", iss_ready, 1);
    chk(iss_tag == TW'(1), "R1", "iss_tag after reset", iss_tag, 1);
    chk(cdb_valid == 1'b0, "R1", "cdb_valid after reset", cdb_valid, 0);

    // R7: two consumers of slot 1 wake together; slot 2 must go first
    n_log = 0;
    step(1'b1, 2'd0, 0, 1, 0);
    @(negedge clk); step(1'b1, 2'd1, 0, 2, 1);
    @(negedge clk); step(1'b1, 2'd2, 0, 3, 2);
    drain();
    chk(n_log == 3, "R7", "broadcast count", n_log, 3);
    chk(log_tag[0] == 1 && log_tag[1] == 2 && log_tag[2] == 3, "R7", "lowest ready first",
        {log_tag[1][7:0], log_tag[2][7:0]}, 16'h0203);

    // R5: consumer issued in the very cycle its producer is on the bus
    n_log = 0;
    @(negedge clk); step(1'b1, 2'd3, 3, 2, 3);
    begin
      bit sent;
      sent = 1'b0;
      for (int k = 0; k < 20 && !sent; k++) begin
        @(negedge clk);
        if (cdb_valid && cdb_tag == TW'(1)) begin
          chk(rtag[3] == 1, "R5", "register still waits on bus tag", rtag[3], 1);
          step(1'b1, 2'd0, 3, 1, 0);
          sent = 1'b1;
        end else step(1'b0, 2'd0, 0, 0, 0);
      end
      chk(sent, "R5", "producer seen on bus", sent, 1);
    end
    drain();
    chk(n_log == 2, "R5", "bypassed consumer completed", n_log, 2);

    // R9: fill every slot, then request again
    n_log = 0;
    for (int i = 0; i < N; i++) begin
      @(negedge clk); step(1'b1, 2'(i), i % NR, (i + 1) % NR, i % NR);
    end
    @(negedge clk);
    chk(iss_ready == 1'b0, "R9", "full reports not ready", iss_ready, 0);
    step(1'b1, 2'd0, 0, 0, 0);
    drain();
    chk(n_log == N, "R9", "no extra operation accepted", n_log, N);

    // Random mix exercising R2..R9
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      step($urandom_range(0, 99) < 60, 2'($urandom()), $urandom_range(0, NR - 1),
           $urandom_range(0, NR - 1), $urandom_range(0, NR - 1));
    end
    drain();

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule